// File: doc/BRIEF.md
# Delayed-Carry Fast Add-Compare-Select Unit

This block is one radix-2 add-compare-select cell for a state-parallel trellis decoder. Each cycle it takes the stored path metrics of two predecessor states and the branch metrics of the two edges into its own state. It picks a survivor and registers the survivor's updated metric together with a one-bit decision. To keep the feedback loop short, the 8-bit metric update is cut into two 4-bit halves that run side by side. The carry that leaves the low half while the branch metric is added is not passed to the high half in the same cycle. It is stored next to the metric as a ninth bit and folded into the high half on the next update.

The survivor is chosen with a relaxed comparison. The two high nibbles are compared first, as a modular difference. Only when they are equal does a 5-bit comparison of the low-half sums decide. This comparison can pick a slightly larger metric, but the error is bounded. A helper output turns the registered 9-bit redundant metric into a plain 8-bit two's-complement metric, so that neighbouring logic or a reference model can read it. Survivor storage lives outside this block.

Top module: `fast_acs_dc`

## Requirements
- R1: While the synchronous active-low reset is asserted at a clock edge, the registered metric (pending carry included), the decision and the resolved metric all become zero.
- R2: A stored metric is 9 bits wide: bit 8 holds the pending carry, bits 7:4 the high nibble and bits 3:0 the low nibble. Its resolved value is ({high,low} + 16*carry) mod 256.
- R3: The new low nibble is (selected low nibble + selected branch metric) mod 16. The new pending carry is the carry out of that 4-bit sum.
- R4: The new high nibble is (selected high nibble + selected pending carry) mod 16. The carry produced in the same cycle never reaches the high nibble.
- R5: Let d = (high_a − high_b) mod 16. When d is nonzero, the decision is 1 (candidate b survives) if d lies in 1..7, and 0 (candidate a survives) if d lies in 8..15.
- R6: When the high nibbles are equal, the 5-bit sums low_a+bm_a and low_b+bm_b are compared. The decision is 1 only when b's sum is strictly smaller; a tie keeps candidate a.
- R7: One cycle after the inputs are applied, the resolved output equals (resolved selected input + selected branch metric) mod 256.
- R8: When the resolved input metrics differ by at most 63 as signed 8-bit values, the surviving updated metric exceeds the smaller of the two exact updated metrics by less than 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pm_a_i | input | 9 | Stored metric of predecessor a (carry, high, low) |
| pm_b_i | input | 9 | Stored metric of predecessor b (carry, high, low) |
| bm_a_i | input | 4 | Branch metric on the edge from a |
| bm_b_i | input | 4 | Branch metric on the edge from b |
| pm_o | output | 9 | Registered updated metric in redundant form |
| dec_o | output | 1 | Registered decision, 1 means b survived |
| pm_res_o | output | 8 | pm_o resolved to a plain 8-bit metric |

## Verification
The sweep walks every 9-bit value of one metric against many offsets of the other, under many branch-metric pairs. This reaches the cases where the low sum carries out, where a pending carry wraps the high nibble past 15, where the nibble difference is exactly 8, and where the high nibbles tie and the low sums tie as well. A design that added the carry into the high half at once would break R4 wherever the low sum overflows. A design that folded the pending carry into the low half would misreport the resolved metric. A design that compared nibbles without modular wrap would choose the wrong survivor across the 7/8 boundary, and a design that broke ties toward b would fail R6. The bound of R8 catches a relaxed compare that drops the low-sum stage or mixes up the halves.

// File: rtl/acs_dc_pkg.sv
// Package: shared widths and the redundant metric type of the delayed-carry
// add-compare-select cell. Assumes branch metrics are exactly one nibble wide.
package acs_dc_pkg;
    parameter int unsigned NIB_W = 4;
    localparam int unsigned BM_W  = NIB_W;
    localparam int unsigned VAL_W = 2 * NIB_W;
    localparam int unsigned PM_W  = VAL_W + 1;
    localparam int unsigned NCAND = 2;

    typedef struct packed {
        logic             carry;
        logic [NIB_W-1:0] hi;
        logic [NIB_W-1:0] lo;
    } metric_t;
endpackage

// File: rtl/acs_dc_low_add.sv
// Low-half adder: adds a branch metric to the low nibble of a stored metric.
// Returns the full NIB_W+1 bit sum; the top bit is the carry that gets deferred.
module acs_dc_low_add #(
    parameter int unsigned NIB_W = 4
) (
    input  logic [NIB_W-1:0] lo_i,
    input  logic [NIB_W-1:0] bm_i,
    output logic [NIB_W:0]   sum_o
);
    // Unsigned add, widened by one bit to keep the carry out.
    always_comb begin
        sum_o = {1'b0, lo_i} + {1'b0, bm_i};
    end
endmodule

// File: rtl/acs_dc_high_fold.sv
// High-half fold: adds the pending carry stored from the previous update into
// the high nibble, wrapping modulo 2**NIB_W (metrics are modular two's complement).
module acs_dc_high_fold #(
    parameter int unsigned NIB_W = 4
) (
    input  logic [NIB_W-1:0] hi_i,
    input  logic             carry_i,
    output logic [NIB_W-1:0] hi_o
);
    // Increment by the deferred carry, the wrap is intended.
    always_comb begin
        hi_o = hi_i + {{(NIB_W-1){1'b0}}, carry_i};
    end
endmodule

// File: rtl/acs_dc_relaxed_cmp.sv
// Relaxed compare: decides between two candidates from a modular compare of
// the stored high nibbles, falling back to the low-half sums on a tie.
// Output 1 selects candidate b. Assumes metrics are normalised modularly.
module acs_dc_relaxed_cmp #(
    parameter int unsigned NIB_W = 4
) (
    input  logic [NIB_W-1:0] hi_a_i,
    input  logic [NIB_W-1:0] hi_b_i,
    input  logic [NIB_W:0]   sum_a_i,
    input  logic [NIB_W:0]   sum_b_i,
    output logic             dec_o
);
    logic [NIB_W-1:0] hi_diff;
    logic             hi_tie;
    logic             lo_b_less;

    // Modular high difference; its sign says which high part is smaller.
    always_comb begin
        hi_diff   = hi_a_i - hi_b_i;
        hi_tie    = (hi_diff == '0);
        lo_b_less = (sum_b_i < sum_a_i);
    end

    // Final pick: high parts decide unless tied, ties keep candidate a.
    always_comb begin
        if (hi_tie) begin
            dec_o = lo_b_less;
        end else begin
            dec_o = ~hi_diff[NIB_W-1];
        end
    end

    // R6
    always_comb begin
        tie_rule_chk: assert (!(hi_a_i == hi_b_i && sum_a_i == sum_b_i) || dec_o == 1'b0)
            else $error("tie between candidates did not keep candidate a");
    end
endmodule

// File: rtl/acs_dc_resolve.sv
// Resolver: turns a redundant metric (carry, high, low) into a plain metric
// by adding the pending carry at the high-nibble weight, modulo 2**(2*NIB_W).
module acs_dc_resolve #(
    parameter int unsigned NIB_W = 4
) (
    input  logic [2*NIB_W:0]   pm_i,
    output logic [2*NIB_W-1:0] val_o
);
    logic [2*NIB_W-1:0] carry_w;

    // Place the deferred carry at the low bit of the high nibble and add.
    always_comb begin
        carry_w = '0;
        carry_w[NIB_W] = pm_i[2*NIB_W];
        val_o = pm_i[2*NIB_W-1:0] + carry_w;
    end
endmodule

// File: rtl/fast_acs_dc.sv
// Delayed-carry fast ACS cell. Both candidates are updated in parallel halves:
// the low nibble takes the branch metric and saves its carry, and the high
// nibble takes the carry saved last time. A relaxed compare picks the
// survivor. The result is registered; reset is synchronous and active low.
module fast_acs_dc
    import acs_dc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PM_W-1:0]  pm_a_i,
    input  logic [PM_W-1:0]  pm_b_i,
    input  logic [BM_W-1:0]  bm_a_i,
    input  logic [BM_W-1:0]  bm_b_i,
    output logic [PM_W-1:0]  pm_o,
    output logic             dec_o,
    output logic [VAL_W-1:0] pm_res_o
);
    metric_t          cand_pm   [NCAND];
    logic [BM_W-1:0]  cand_bm   [NCAND];
    logic [NIB_W:0]   cand_sum  [NCAND];
    logic [NIB_W-1:0] cand_hi   [NCAND];
    metric_t          cand_next [NCAND];
    logic             dec_c;
    metric_t          pm_q;
    logic             dec_q;

    // Gather candidate inputs into arrays for the per-candidate datapath.
    always_comb begin
        cand_pm[0] = metric_t'(pm_a_i);
        cand_pm[1] = metric_t'(pm_b_i);
        cand_bm[0] = bm_a_i;
        cand_bm[1] = bm_b_i;
    end

    for (genvar g = 0; g < NCAND; g++) begin : g_cand
        acs_dc_low_add #(.NIB_W(NIB_W)) u_low (
            .lo_i  (cand_pm[g].lo),
            .bm_i  (cand_bm[g]),
            .sum_o (cand_sum[g])
        );

        acs_dc_high_fold #(.NIB_W(NIB_W)) u_high (
            .hi_i    (cand_pm[g].hi),
            .carry_i (cand_pm[g].carry),
            .hi_o    (cand_hi[g])
        );

        // Assemble the candidate's next redundant metric.
        always_comb begin
            cand_next[g].carry = cand_sum[g][NIB_W];
            cand_next[g].hi    = cand_hi[g];
            cand_next[g].lo    = cand_sum[g][NIB_W-1:0];
        end
    end

    acs_dc_relaxed_cmp #(.NIB_W(NIB_W)) u_cmp (
        .hi_a_i  (cand_pm[0].hi),
        .hi_b_i  (cand_pm[1].hi),
        .sum_a_i (cand_sum[0]),
        .sum_b_i (cand_sum[1]),
        .dec_o   (dec_c)
    );

    // Register the survivor's metric and the decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pm_q  <= '0;
            dec_q <= 1'b0;
        end else begin
            pm_q  <= dec_c ? cand_next[1] : cand_next[0];
            dec_q <= dec_c;
        end
    end

    assign pm_o  = pm_q;
    assign dec_o = dec_q;

    acs_dc_resolve #(.NIB_W(NIB_W)) u_res_out (
        .pm_i  (pm_q),
        .val_o (pm_res_o)
    );

    // Resolved views of the inputs, used only by the checks below.
    logic [VAL_W-1:0] res_a_chk;
    logic [VAL_W-1:0] res_b_chk;

    acs_dc_resolve #(.NIB_W(NIB_W)) u_res_a (
        .pm_i  (pm_a_i),
        .val_o (res_a_chk)
    );

    acs_dc_resolve #(.NIB_W(NIB_W)) u_res_b (
        .pm_i  (pm_b_i),
        .val_o (res_b_chk)
    );

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !$past(rst_n) |-> (pm_o == '0 && dec_o == 1'b0))
        else $error("state not cleared by reset");

    // R7
    resolved_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> pm_res_o == ($past(dec_c)
            ? $past(res_b_chk) + VAL_W'($past(bm_b_i))
            : $past(res_a_chk) + VAL_W'($past(bm_a_i))))
        else $error("resolved metric does not track selected input");

    // R4
    high_fold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> pm_o[VAL_W-1:NIB_W] == (dec_o
            ? $past(pm_b_i[VAL_W-1:NIB_W]) + NIB_W'($past(pm_b_i[VAL_W]))
            : $past(pm_a_i[VAL_W-1:NIB_W]) + NIB_W'($past(pm_a_i[VAL_W]))))
        else $error("high nibble is not selected high plus pending carry");

    // R3
    low_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> {pm_o[VAL_W], pm_o[NIB_W-1:0]} == (dec_o
            ? {1'b0, $past(pm_b_i[NIB_W-1:0])} + {1'b0, $past(bm_b_i)}
            : {1'b0, $past(pm_a_i[NIB_W-1:0])} + {1'b0, $past(bm_a_i)}))
        else $error("low nibble or new carry wrong");
endmodule

// File: tb/fast_acs_dc_test.sv
// Sweep bench: every 9-bit metric a against many offsets b and branch pairs,
// with all expected values computed arithmetically from the requirements.
module fast_acs_dc_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [8:0] pm_a_i = '0;
    logic [8:0] pm_b_i = '0;
    logic [3:0] bm_a_i = '0;
    logic [3:0] bm_b_i = '0;
    logic [8:0] pm_o;
    logic       dec_o;
    logic [7:0] pm_res_o;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    fast_acs_dc uut (
        .clk(clk), .rst_n(rst_n),
        .pm_a_i(pm_a_i), .pm_b_i(pm_b_i),
        .bm_a_i(bm_a_i), .bm_b_i(bm_b_i),
        .pm_o(pm_o), .dec_o(dec_o), .pm_res_o(pm_res_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int resolve(input logic [8:0] p);
        return (int'(p[7:0]) + 16 * int'(p[8])) % 256;
    endfunction

    function automatic int sgn8(input int v);
        int w = v & 255;
        return (w >= 128) ? w - 256 : w;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d (a=%0d b=%0d bma=%0d bmb=%0d)",
                     req, act, exp, pm_a_i, pm_b_i, bm_a_i, bm_b_i);
        end
    endtask

    task automatic apply(input logic [8:0] a, input logic [8:0] b,
                         input logic [3:0] ba, input logic [3:0] bb);
        int d, sa, sb, exp_dec, sel_lo, sel_hi, sel_c, sel_bm, sum;
        int exp_pm, exp_res, ra, rb, ta, tb, tsel, tmin;
        logic [8:0] sel;
        @(negedge clk);
        pm_a_i = a; pm_b_i = b; bm_a_i = ba; bm_b_i = bb;
        d  = (int'(a[7:4]) - int'(b[7:4])) & 15;
        sa = int'(a[3:0]) + int'(ba);
        sb = int'(b[3:0]) + int'(bb);
        if (d != 0) exp_dec = (d <= 7) ? 1 : 0;   // R5
        else        exp_dec = (sb < sa) ? 1 : 0;  // R6
        sel    = exp_dec ? b : a;
        sel_bm = exp_dec ? int'(bb) : int'(ba);
        sel_lo = int'(sel[3:0]);
        sel_hi = int'(sel[7:4]);
        sel_c  = int'(sel[8]);
        sum    = sel_lo + sel_bm;
        exp_pm = ((sum >> 4) << 8) | (((sel_hi + sel_c) & 15) << 4) | (sum & 15);
        ra = resolve(a); rb = resolve(b);
        exp_res = ((exp_dec ? rb : ra) + sel_bm) & 255;
        @(posedge clk);
        #1;
        check(d != 0 ? "R5" : "R6", int'(dec_o), exp_dec);
        check("R3", int'({pm_o[8], pm_o[3:0]}), ((sum >> 4) << 4) | (sum & 15));
        check("R4", int'(pm_o[7:4]), (sel_hi + sel_c) & 15);
        check("R2", int'(pm_o), exp_pm);
        check("R7", int'(pm_res_o), exp_res);
        if (sgn8(ra - rb) >= -63 && sgn8(ra - rb) <= 63) begin
            ta = int'(ba) + sgn8(ra - rb);
            tb = int'(bb);
            tsel = exp_dec ? tb : ta;
            tmin = (ta < tb) ? ta : tb;
            check("R8", (tsel - tmin) < 32 ? 1 : 0, 1);
        end
    endtask

    initial begin
        rst_n = 1'b0;
        pm_a_i = 9'h1FF; pm_b_i = 9'h1F0; bm_a_i = 4'hF; bm_b_i = 4'hF;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state of all outputs
        check("R1", int'(pm_o), 0);
        check("R1", int'(dec_o), 0);
        check("R1", int'(pm_res_o), 0);
        @(negedge clk);
        rst_n = 1'b1;
        // Directed corners: carry wrap of high, difference exactly 8, full tie.
        apply(9'h1F8, 9'h0F8, 4'd8, 4'd8);
        apply(9'h080, 9'h000, 4'd0, 4'd0);
        apply(9'h055, 9'h055, 4'd3, 4'd3);
        apply(9'h14F, 9'h04F, 4'd1, 4'd2);
        for (int a = 0; a < 512; a++) begin
            for (int k = 0; k < 40; k++) begin
                apply(9'(a), 9'((a + k * 13 + (k >> 3)) & 511),
                      4'(k & 15), 4'((a + k * 5) & 15));
            end
        end
        // R1: reset in mid-run clears a nonzero state
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check("R1", int'(pm_o), 0);
        check("R1", int'(pm_res_o), 0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_vec++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule